// File: doc/BRIEF.md
# Display Control Bus Master

This block drives a narrow byte-wide control bus that serves up to sixteen devices in a display pipeline. Software first loads a mode word. The mode word picks the target device, a starting register select, how many bytes each data access carries, whether the select advances after every byte, whether the device acknowledges, and how many clock cycles chip select spends in setup, in its active phase and in hold. A write or read of the data port then starts a transfer. The controller breaks the 32-bit word into a series of byte cycles on the bus, sending the top byte first. On a read it gathers the returned bytes.

A busy output stays high for the whole transfer, so software can poll it. Requests that arrive while busy is high are dropped. When acknowledge is enabled and the device stays silent, a cycle limit ends the transfer and raises an error flag. The next transfer clears that flag.

Top module: `dcb_master`

## Requirements
- R1: After reset, busy, err, bus_cs and host_rdata are all zero.
- R2: A mode write (host_mode_wr) stores host_wdata[27:0] with this field layout: size code [1:0], full-word bit [2], select-advance bit [3], start register select [6:4], device address [10:7], clocked-acknowledge enable [11], free-running-acknowledge enable [12], active length [17:13], hold length [22:18], setup length [27:23]. bus_addr always shows the stored device address.
- R3: The bytes per transfer are four when the full-word bit is set. Otherwise they follow the size code: 0 gives four bytes, and 1, 2 or 3 give that many bytes.
- R4: bus_dout carries the bytes of the data word from bits [31:24] downward, one byte per byte cycle. bus_we is high during a write transfer and low during a read.
- R5: Each byte cycle has three parts in order. First comes setup: bus_cs is low for the setup length. Then bus_cs is high for active length + 1 cycles. Last comes hold: bus_cs is low for the hold length. A setup or hold length of zero takes no cycles.
- R6: When the select-advance bit is set, bus_crs goes up by one (modulo 8) after each byte. When it is clear, bus_crs keeps the start value for the whole transfer.
- R7: When the clocked-acknowledge enable is set, the active phase ignores the active length. It ends in the cycle where bus_ack_sync is sampled high.
- R8: When the free-running-acknowledge enable is set, bus_ack_async first passes through SYNC_STAGES flip-flops. The active phase ends in the cycle where the synchronized level is high.
- R9: When acknowledge is enabled and none arrives for TMO_CYCLES active cycles, the transfer ends at once and err is set. err is cleared when the next transfer starts.
- R10: busy rises in the cycle after a data write or data read request is accepted. It stays high until the last hold cycle is over.
- R11: Mode writes and data requests that arrive while busy is high have no effect.
- R12: On a read, the device byte on bus_din is captured in the last active cycle of each byte and shifted into host_rdata from the bottom. host_rdata is cleared when the read starts, so the first byte ends up in the highest byte that holds data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_mode_wr | input | 1 | Load mode word from host_wdata |
| host_data_wr | input | 1 | Start a write transfer of host_wdata |
| host_data_rd | input | 1 | Start a read transfer (wins if both are set) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Collected read bytes |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Acknowledge timeout occurred |
| bus_addr | output | 4 | Device address |
| bus_crs | output | 3 | Register select |
| bus_cs | output | 1 | Chip select, active high |
| bus_we | output | 1 | Write direction |
| bus_dout | output | 8 | Byte to the device |
| bus_din | input | 8 | Byte from the device |
| bus_ack_sync | input | 1 | Acknowledge in the controller's clock domain |
| bus_ack_async | input | 1 | Acknowledge from a foreign clock domain |

## Verification
The bench builds the block with TMO_CYCLES set to 16 and SYNC_STAGES kept at 2. The short limit makes the acknowledge timeout reachable in a few dozen cycles, so the bench can check the exact cycle where the transfer is cut off and the error flag is set. With two synchronizer stages, the free-running acknowledge path arrives exactly two cycles late. A model that counts cycles can therefore predict an active phase of three cycles for both acknowledge styles. The timing values tested include zero setup and zero hold, the 5/5/0 write setting and the read setting 2/1/3.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

   typedef struct packed {
      logic [4:0] setup;
      logic [4:0] hold;
      logic [4:0] act_len;
      logic       ack_free;
      logic       ack_clk;
      logic [3:0] addr;
      logic [2:0] crs;
      logic       crs_adv;
      logic       full_word;
      logic [1:0] size;
   } mode_t;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_ACT   = 2'd2,
      PH_HOLD  = 2'd3
   } phase_e;

   function automatic logic [2:0] bytes_of(mode_t m);
      if (m.full_word || m.size == 2'd0) return 3'd4;
      return {1'b0, m.size};
   endfunction

endpackage

// File: rtl/dcb_ack_sync.sv
module dcb_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain[0] <= d;
               for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/dcb_seq.sv
module dcb_seq
   import dcb_pkg::*;
#(
   parameter int TMO_CYCLES = 256
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        start_rd,
   input  mode_t       mode,
   input  logic [31:0] wdata,
   input  logic [7:0]  din,
   input  logic        ack_clk_in,
   input  logic        ack_free_in,
   output logic        busy,
   output logic        err,
   output logic [3:0]  addr,
   output logic [2:0]  crs,
   output logic        cs,
   output logic        we,
   output logic [7:0]  dout,
   output logic [31:0] rdata
);
   localparam int TMO_W = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;
   localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYCLES - 1);

   phase_e           ph, ph_d;
   logic [5:0]       cnt, cnt_d;
   logic [TMO_W-1:0] tmo_cnt, tmo_d;
   logic [2:0]       left;
   logic [31:0]      wsh;
   logic             is_rd;
   logic             byte_done, tmo_hit;

   wire        ack_mode  = mode.ack_clk | mode.ack_free;
   wire        ack_seen  = (mode.ack_clk & ack_clk_in) | (mode.ack_free & ack_free_in);
   wire [5:0]  act_load  = {1'b0, mode.act_len} + 6'd1;
   wire        has_setup = (mode.setup != 5'd0);

   always_comb begin
      ph_d      = ph;
      cnt_d     = cnt;
      tmo_d     = tmo_cnt;
      byte_done = 1'b0;
      tmo_hit   = 1'b0;
      case (ph)
         PH_IDLE: begin
            if (start) begin
               ph_d  = has_setup ? PH_SETUP : PH_ACT;
               cnt_d = has_setup ? {1'b0, mode.setup} : act_load;
               tmo_d = '0;
            end
         end
         PH_SETUP: begin
            if (cnt == 6'd1) begin
               ph_d  = PH_ACT;
               cnt_d = act_load;
               tmo_d = '0;
            end else begin
               cnt_d = cnt - 6'd1;
            end
         end
         PH_ACT: begin
            tmo_d = tmo_cnt + 1'b1;
            if (ack_mode) begin
               if (ack_seen) byte_done = 1'b1;
               else if (tmo_cnt == TMO_LAST) begin
                  tmo_hit = 1'b1;
                  ph_d    = PH_IDLE;
               end
            end else if (cnt == 6'd1) begin
               byte_done = 1'b1;
            end else begin
               cnt_d = cnt - 6'd1;
            end
            if (byte_done) begin
               if (mode.hold != 5'd0) begin
                  ph_d  = PH_HOLD;
                  cnt_d = {1'b0, mode.hold};
               end else if (left > 3'd1) begin
                  ph_d  = has_setup ? PH_SETUP : PH_ACT;
                  cnt_d = has_setup ? {1'b0, mode.setup} : act_load;
                  tmo_d = '0;
               end else begin
                  ph_d = PH_IDLE;
               end
            end
         end
         PH_HOLD: begin
            if (cnt == 6'd1) begin
               if (left != 3'd0) begin
                  ph_d  = has_setup ? PH_SETUP : PH_ACT;
                  cnt_d = has_setup ? {1'b0, mode.setup} : act_load;
                  tmo_d = '0;
               end else begin
                  ph_d = PH_IDLE;
               end
            end else begin
               cnt_d = cnt - 6'd1;
            end
         end
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_IDLE;
         cnt     <= '0;
         tmo_cnt <= '0;
         left    <= '0;
         crs     <= '0;
         wsh     <= '0;
         rdata   <= '0;
         is_rd   <= 1'b0;
         err     <= 1'b0;
      end else begin
         ph      <= ph_d;
         cnt     <= cnt_d;
         tmo_cnt <= tmo_d;
         if (ph == PH_IDLE && start) begin
            left  <= bytes_of(mode);
            crs   <= mode.crs;
            wsh   <= wdata;
            is_rd <= start_rd;
            err   <= 1'b0;
            if (start_rd) rdata <= '0;
         end
         if (byte_done) begin
            left <= left - 3'd1;
            crs  <= crs + {2'b00, mode.crs_adv};
            wsh  <= {wsh[23:0], 8'h00};
            if (is_rd) rdata <= {rdata[23:0], din};
         end
         if (tmo_hit) err <= 1'b1;
      end
   end

   assign busy = (ph != PH_IDLE);
   assign cs   = (ph == PH_ACT);
   assign we   = busy & ~is_rd;
   assign dout = wsh[31:24];
   assign addr = mode.addr;

   // R6
   crs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> (crs == $past(crs) + {2'b00, $past(mode.crs_adv)}));
   // R9
   tmo_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_hit |=> (err && !busy));
   // R5
   act_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_ACT && !ack_mode && cnt > 6'd1) |=> cs);
endmodule

// File: rtl/dcb_master.sv
module dcb_master
   import dcb_pkg::*;
#(
   parameter int TMO_CYCLES  = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_mode_wr,
   input  logic        host_data_wr,
   input  logic        host_data_rd,
   input  logic [31:0] host_wdata,
   output logic [31:0] host_rdata,
   output logic        busy,
   output logic        err,
   output logic [3:0]  bus_addr,
   output logic [2:0]  bus_crs,
   output logic        bus_cs,
   output logic        bus_we,
   output logic [7:0]  bus_dout,
   input  logic [7:0]  bus_din,
   input  logic        bus_ack_sync,
   input  logic        bus_ack_async
);
   localparam int MODE_W = $bits(mode_t);

   generate
      if (TMO_CYCLES < 2) begin : g_bad_tmo
         $error("TMO_CYCLES must be at least 2");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must not exceed 4");
      end
   endgenerate

   mode_t mode_q;
   logic  ack_free_s;
   wire   start = (host_data_wr | host_data_rd) & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= '0;
      else if (host_mode_wr && !busy) mode_q <= mode_t'(host_wdata[MODE_W-1:0]);
   end

   dcb_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_ack_async), .q(ack_free_s)
   );

   dcb_seq #(.TMO_CYCLES(TMO_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_rd(host_data_rd),
      .mode(mode_q), .wdata(host_wdata), .din(bus_din),
      .ack_clk_in(bus_ack_sync), .ack_free_in(ack_free_s),
      .busy(busy), .err(err), .addr(bus_addr), .crs(bus_crs),
      .cs(bus_cs), .we(bus_we), .dout(bus_dout), .rdata(host_rdata)
   );

   // R10
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   // R11
   mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mode_q));
   // R5
   cs_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cs |-> busy);
endmodule

// File: tb/dcb_master_tb_top.sv
module dcb_master_tb_top;
   localparam int TMO = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_mode_wr = 1'b0, host_data_wr = 1'b0, host_data_rd = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        busy, err, bus_cs, bus_we;
   logic [3:0]  bus_addr;
   logic [2:0]  bus_crs;
   logic [7:0]  bus_dout, bus_din;
   logic        bus_ack_sync, bus_ack_async;
   logic        resp_en = 1'b0;
   logic        hist0 = 1'b0, hist1 = 1'b0;

   int          n_run = 0, n_fail = 0;
   bit          done = 0;
   logic [31:0] cur_mode = '0;

   always #4 clk = ~clk;

   always @(posedge clk) begin
      hist0 <= bus_cs;
      hist1 <= hist0;
   end
   assign bus_ack_sync  = resp_en & bus_cs & hist0 & hist1;
   assign bus_ack_async = resp_en & bus_cs;
   assign bus_din       = 8'hC0 | {5'd0, bus_crs};

   dcb_master #(.TMO_CYCLES(TMO), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_mode_wr(host_mode_wr),
      .host_data_wr(host_data_wr), .host_data_rd(host_data_rd),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
      .err(err), .bus_addr(bus_addr), .bus_crs(bus_crs), .bus_cs(bus_cs),
      .bus_we(bus_we), .bus_dout(bus_dout), .bus_din(bus_din),
      .bus_ack_sync(bus_ack_sync), .bus_ack_async(bus_ack_async)
   );

   function automatic logic [31:0] mk(int su, int ho, int al, bit af, bit ac,
                                      int ad, int cr, bit adv, bit fw, int sz);
      return (32'(su) << 23) | (32'(ho) << 18) | (32'(al) << 13) |
             (32'(af) << 12) | (32'(ac) << 11) | (32'(ad) << 7) |
             (32'(cr) << 4) | (32'(adv) << 3) | (32'(fw) << 2) | 32'(sz);
   endfunction

   task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic set_mode(logic [31:0] m);
      @(negedge clk);
      host_mode_wr = 1'b1;
      host_wdata   = m;
      @(negedge clk);
      host_mode_wr = 1'b0;
      cur_mode     = m;
   endtask

   task automatic xfer(logic [31:0] d, bit rd, bit resp, bit inj, string req);
      int q_cs[$], q_crs[$], q_dout[$];
      int su = int'(cur_mode[27:23]), ho = int'(cur_mode[22:18]);
      int al = int'(cur_mode[17:13]);
      bit ackm = cur_mode[12] | cur_mode[11];
      int cr0 = int'(cur_mode[6:4]);
      int n = (cur_mode[2] || cur_mode[1:0] == 2'd0) ? 4 : int'(cur_mode[1:0]);
      int alen = ackm ? (resp ? 3 : TMO) : al + 1;
      logic [31:0] exp_rd = '0;
      bit exp_err = 0;
      for (int b = 0; b < n; b++) begin
         int c = (cr0 + (cur_mode[3] ? b : 0)) % 8;
         int by = int'((d >> (24 - 8 * b)) & 32'hFF);
         for (int k = 0; k < su; k++) begin q_cs.push_back(0); q_crs.push_back(c); q_dout.push_back(by); end
         for (int k = 0; k < alen; k++) begin q_cs.push_back(1); q_crs.push_back(c); q_dout.push_back(by); end
         if (ackm && !resp) begin exp_err = 1; break; end
         exp_rd = (exp_rd << 8) | (32'hC0 | 32'(c));
         for (int k = 0; k < ho; k++) begin q_cs.push_back(0); q_crs.push_back(c); q_dout.push_back(by); end
      end
      @(negedge clk);
      host_wdata   = d;
      host_data_wr = !rd;
      host_data_rd = rd;
      resp_en      = resp;
      @(negedge clk);
      host_data_wr = 1'b0;
      host_data_rd = 1'b0;
      for (int i = 0; i < q_cs.size(); i++) begin
         bit ok = busy && (bus_cs == q_cs[i][0]) && (bus_we == !rd) &&
                  (bus_addr == cur_mode[10:7]) &&
                  (!bus_cs || bus_crs == 3'(q_crs[i])) &&
                  (!bus_cs || rd || bus_dout == 8'(q_dout[i]));
         check(ok, req, $sformatf("cycle %0d cs/crs/dout", i),
               {busy, bus_cs, bus_we, 10'd0, bus_crs, 8'd0, bus_dout},
               {1'b1, q_cs[i][0], !rd, 10'd0, 3'(q_crs[i]), 8'd0, 8'(q_dout[i])});
         if (inj && i == 1) begin
            host_mode_wr = 1'b1;
            host_data_wr = 1'b1;
            host_wdata   = ~d;
         end
         if (inj && i == 2) begin
            host_mode_wr = 1'b0;
            host_data_wr = 1'b0;
         end
         @(negedge clk);
      end
      host_mode_wr = 1'b0;
      host_data_wr = 1'b0;
      check(!busy && !bus_cs, "R10", "busy end", {30'd0, busy, bus_cs}, 32'd0);
      check(err == exp_err, "R9", "err", {31'd0, err}, {31'd0, exp_err});
      if (rd) check(host_rdata == exp_rd, "R12", "read word", host_rdata, exp_rd);
      resp_en = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!busy && !err && !bus_cs && host_rdata == 0, "R1", "reset",
            {29'd0, busy, err, bus_cs}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 R3 R4 R5: one byte, setup 2 hold 1 width 0
      set_mode(mk(2, 1, 0, 0, 0, 5, 3, 0, 0, 1));
      check(bus_addr == 4'd5, "R2", "address field", {28'd0, bus_addr}, 32'd5);
      xfer(32'hA1B2C3D4, 0, 0, 0, "R4");
      // R3 R6: size 0 gives four bytes, select wraps 6,7,0,1, timing 5/5/0
      set_mode(mk(5, 5, 0, 0, 0, 2, 6, 1, 0, 0));
      xfer(32'h11223344, 0, 0, 0, "R6");
      // R3 R5: full-word bit overrides size 2, zero setup and hold
      set_mode(mk(0, 0, 2, 0, 0, 9, 1, 0, 1, 2));
      xfer(32'hDEADBEEF, 0, 0, 0, "R3");
      // R3 R5: three bytes, setup 1 hold 0 width 4
      set_mode(mk(1, 0, 4, 0, 0, 11, 0, 1, 0, 3));
      xfer(32'h0F1E2D3C, 0, 0, 0, "R5");
      // R12: read, timing 2/1/3, three bytes, advancing select
      set_mode(mk(2, 1, 3, 0, 0, 4, 2, 1, 0, 3));
      xfer(32'h0, 1, 0, 0, "R12");
      // R7: clocked acknowledge
      set_mode(mk(2, 1, 0, 0, 1, 6, 0, 1, 0, 2));
      xfer(32'h5566AA99, 0, 1, 0, "R7");
      // R8: free-running acknowledge through synchronizer
      set_mode(mk(2, 1, 0, 1, 0, 7, 4, 0, 0, 2));
      xfer(32'h12345678, 0, 1, 0, "R8");
      // R9: timeout with a silent device, then a clean transfer clears err
      set_mode(mk(1, 1, 0, 0, 1, 3, 0, 0, 0, 2));
      xfer(32'hCAFEF00D, 0, 0, 0, "R9");
      set_mode(mk(1, 1, 0, 0, 0, 3, 0, 0, 0, 1));
      xfer(32'h80000000, 0, 0, 0, "R9");
      // R11: writes while busy are dropped; next transfer keeps the old mode
      set_mode(mk(2, 2, 1, 0, 0, 8, 5, 1, 0, 2));
      xfer(32'h13579BDF, 0, 0, 1, "R11");
      xfer(32'h2468ACE0, 0, 0, 0, "R11");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule